// File: doc/BRIEF.md
# PLL Frequency Lock Monitor

This block decides whether a PLL output runs at the intended frequency. It counts cycles of the reference clock and of the PLL feedback clock over the same measurement window and compares the two counts at the end of each window. Phase is never examined: agreement of the cycle counts is taken as frequency lock.

Acquisition takes two consecutive agreeing windows. The first is N reference cycles long and the second is N+K cycles long, and both use a tight tolerance TOL. Once both agree, the block raises a live lock flag and a sticky flag. It then keeps checking windows of N cycles, with the tolerance widened to 2*TOL. Any window that disagrees drops the live flag, brings back the tight tolerance and starts acquisition again from the short window. The sticky flag survives loss of lock. Only reset or a clear pulse removes it.

The feedback count is kept in Gray code and carried into the reference domain through two flops. The reference domain snapshots it at each window boundary, and the difference between two snapshots is the feedback count for that window. The first window after reset only takes the initial snapshot.

Top module: `pll_freq_lock_mon`

## Requirements
- R1: While `rst_n` is low, and after its release until lock is declared, `lock` and `lock_sticky` read 0.
- R2: After reset release, the first N-cycle window is discarded. Lock is declared only at the end of the following N-cycle window and N+K-cycle window when both agree. With equal clocks and N=32, K=16, `lock` is 0 at 105 reference cycles after release and 1 at 125.
- R3: Before lock, a window agrees only when the feedback count differs from the window length by at most TOL. A feedback clock 38/32 or 26/32 times the reference frequency never acquires lock with TOL=4.
- R4: While locked, windows are N cycles long and a difference of up to 2*TOL keeps `lock` at 1. Both the 38/32 and the 26/32 ratios hold lock with TOL=4.
- R5: A disagreeing window clears `lock`, restores the tolerance TOL and restarts acquisition from the N-cycle window.
- R6: `lock_sticky` is set in the same cycle that lock is declared and stays set when lock is lost.
- R7: A one-cycle pulse on `locks_clr` clears `lock_sticky` one clock later and leaves `lock` unchanged. If lock is declared in the same cycle, setting wins.
- R8: The feedback count crosses into the reference domain as a Gray code, so consecutive values of the register that is sent differ in at most one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; the window timing and both flags are in this domain |
| fb_clk | input | 1 | PLL feedback clock whose cycles are counted |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized separately into each domain |
| locks_clr | input | 1 | Reference-domain pulse that clears the sticky flag |
| lock | output | 1 | Live frequency-lock flag |
| lock_sticky | output | 1 | Set when lock is declared; cleared only by reset or `locks_clr` |

## Verification
The assertions assume that the feedback clock runs freely and never exceeds RATIO_MAX times the reference frequency. Under that condition the free-running Gray counter cannot wrap within one window, and the sent code steps by exactly one bit per feedback edge. The stimulus only switches the feedback period between fixed values that stay within that ratio. It keeps `locks_clr` to single reference-cycle pulses driven on the falling edge. Each frequency change is given several full windows to settle before any flag is sampled.

// File: rtl/pll_freq_lock_mon.sv
`timescale 1ns/1ps
module pll_freq_lock_mon #(
  parameter int N         = 32,
  parameter int K         = 16,
  parameter int TOL       = 4,
  parameter int RATIO_MAX = 4
) (
  input  logic ref_clk,
  input  logic fb_clk,
  input  logic rst_n,
  input  logic locks_clr,
  output logic lock,
  output logic lock_sticky
);
  localparam int LONG = N + K;
  localparam int RCW  = $clog2(LONG + 1);
  localparam int FCW  = $clog2(LONG * RATIO_MAX + 1) + 1;

  localparam logic [1:0] PH_SYNC = 2'd0;
  localparam logic [1:0] PH_N    = 2'd1;
  localparam logic [1:0] PH_NK   = 2'd2;
  localparam logic [1:0] PH_LOCK = 2'd3;

  logic [1:0] ref_rs, fb_rs;
  logic       ref_rst_n, fb_rst_n;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) ref_rs <= 2'b00;
    else        ref_rs <= {ref_rs[0], 1'b1};

  always_ff @(posedge fb_clk or negedge rst_n)
    if (!rst_n) fb_rs <= 2'b00;
    else        fb_rs <= {fb_rs[0], 1'b1};

  assign ref_rst_n = ref_rs[1];
  assign fb_rst_n  = fb_rs[1];

  logic [FCW-1:0] fb_bin, fb_next, fb_gray;
  assign fb_next = fb_bin + 1'b1;

  always_ff @(posedge fb_clk or negedge fb_rst_n)
    if (!fb_rst_n) begin
      fb_bin  <= '0;
      fb_gray <= '0;
    end else begin
      fb_bin  <= fb_next;
      fb_gray <= fb_next ^ (fb_next >> 1);
    end

  logic [FCW-1:0] g_s1, g_s2;

  always_ff @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n) begin
      g_s1 <= '0;
      g_s2 <= '0;
    end else begin
      g_s1 <= fb_gray;
      g_s2 <= g_s1;
    end

  function automatic logic [FCW-1:0] gray2bin(input logic [FCW-1:0] g);
    logic [FCW-1:0] b;
    b[FCW-1] = g[FCW-1];
    for (int i = FCW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [FCW-1:0] fb_now, fb_mark, fb_delta;
  logic [RCW-1:0] ref_cnt, win_len;
  logic [1:0]     phase;
  logic [FCW:0]   len_x, cnt_x, span_err, tol_x;
  logic           win_end, match;

  assign fb_now   = gray2bin(g_s2);
  assign fb_delta = fb_now - fb_mark;
  assign win_len  = (phase == PH_NK) ? RCW'(LONG) : RCW'(N);
  assign win_end  = (ref_cnt == win_len - RCW'(1));
  assign len_x    = (FCW+1)'(win_len);
  assign cnt_x    = {1'b0, fb_delta};
  assign span_err = (cnt_x >= len_x) ? cnt_x - len_x : len_x - cnt_x;
  assign tol_x    = (phase == PH_LOCK) ? (FCW+1)'(2 * TOL) : (FCW+1)'(TOL);
  assign match    = (span_err <= tol_x);

  always_ff @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n) begin
      ref_cnt <= '0;
      fb_mark <= '0;
      phase   <= PH_SYNC;
      lock    <= 1'b0;
    end else if (win_end) begin
      ref_cnt <= '0;
      fb_mark <= fb_now;
      case (phase)
        PH_SYNC: phase <= PH_N;
        PH_N:    phase <= match ? PH_NK : PH_N;
        PH_NK:   begin
          phase <= match ? PH_LOCK : PH_N;
          lock  <= match;
        end
        default: begin
          phase <= match ? PH_LOCK : PH_N;
          lock  <= match;
        end
      endcase
    end else begin
      ref_cnt <= ref_cnt + RCW'(1);
    end

  always_ff @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n)                            lock_sticky <= 1'b0;
    else if (win_end && phase == PH_NK && match) lock_sticky <= 1'b1;
    else if (locks_clr)                        lock_sticky <= 1'b0;

endmodule

module pll_freq_lock_mon_chk #(
  parameter int FCW = 8
) (
  input logic           ref_clk,
  input logic           fb_clk,
  input logic           rst_n,
  input logic           ref_rst_n,
  input logic           fb_rst_n,
  input logic           locks_clr,
  input logic           lock,
  input logic           lock_sticky,
  input logic [1:0]     phase,
  input logic [FCW-1:0] fb_gray
);
  a_r1_reset_clear: assert property (@(posedge ref_clk)
    !rst_n |=> (!lock && !lock_sticky));

  a_r2_lock_after_long: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(lock) |-> $past(phase) == 2'd2);

  a_r5_drop_restarts: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $fell(lock) |-> phase == 2'd1);

  a_r6_sticky_with_lock: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(lock) |-> lock_sticky);

  a_r7_clear_sticky: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    locks_clr |=> (!lock_sticky || $rose(lock)));

  a_r8_gray_step: assert property (@(posedge fb_clk) disable iff (!fb_rst_n)
    $countones(fb_gray ^ $past(fb_gray)) <= 1);
endmodule

bind pll_freq_lock_mon pll_freq_lock_mon_chk #(.FCW(FCW)) u_chk (
  .ref_clk(ref_clk), .fb_clk(fb_clk), .rst_n(rst_n),
  .ref_rst_n(ref_rst_n), .fb_rst_n(fb_rst_n), .locks_clr(locks_clr),
  .lock(lock), .lock_sticky(lock_sticky), .phase(phase), .fb_gray(fb_gray)
);

// File: tb/pll_freq_lock_mon_tb.sv
`timescale 1ns/1ps
module pll_freq_lock_mon_tb;
  localparam realtime CLK_PERIOD = 10.0;
  localparam int      NV = 7;
  localparam int      HALF_PS  [NV] = '{5000, 4210, 6150, 2500, 4210, 6150, 5000};
  localparam bit      EXP_LOCK [NV] = '{1,    1,    1,    0,    0,    0,    1};
  localparam bit      EXP_STK  [NV] = '{1,    1,    1,    1,    1,    1,    1};

  logic ref_clk = 0, fb_clk = 0, rst_n = 0, locks_clr = 0;
  logic lock, lock_sticky;
  realtime fb_half = 5.0;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  pll_freq_lock_mon u_dut (
    .ref_clk(ref_clk), .fb_clk(fb_clk), .rst_n(rst_n),
    .locks_clr(locks_clr), .lock(lock), .lock_sticky(lock_sticky)
  );

  initial forever #(CLK_PERIOD / 2) ref_clk = ~ref_clk;
  initial forever #(fb_half) fb_clk = ~fb_clk;
  always @(posedge ref_clk) cyc++;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  initial begin
    wait (cyc == 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_neg(5);
    chk("R1 lock in reset", lock, 1'b0);
    chk("R1 sticky in reset", lock_sticky, 1'b0);
    rst_n = 1;
    wait_neg(105);
    chk("R2 no lock before N+K window", lock, 1'b0);
    wait_neg(20);
    chk("R2 lock after N and N+K windows", lock, 1'b1);
    chk("R6 sticky set with lock", lock_sticky, 1'b1);

    for (int v = 0; v < NV; v++) begin
      fb_half = HALF_PS[v] / 1000.0;
      wait_neg(250);
      chk($sformatf("R3 R4 R5 lock vector %0d", v), lock, EXP_LOCK[v]);
      chk($sformatf("R6 sticky vector %0d", v), lock_sticky, EXP_STK[v]);
    end

    locks_clr = 1;
    wait_neg(1);
    locks_clr = 0;
    chk("R7 clear drops sticky", lock_sticky, 1'b0);
    chk("R7 clear keeps lock", lock, 1'b1);

    fb_half = 2.5;
    wait_neg(150);
    chk("R5 lock lost after clear", lock, 1'b0);
    chk("R6 sticky not reset by loss", lock_sticky, 1'b0);

    fb_half = 5.0;
    wait_neg(250);
    chk("R6 sticky set again on relock", lock_sticky, 1'b1);

    rst_n = 0;
    wait_neg(3);
    chk("R1 lock cleared by reset", lock, 1'b0);
    chk("R1 sticky cleared by reset", lock_sticky, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule